// File: doc/BRIEF.md
# Memory Region Security Filter

This block is an address firewall placed in front of a DRAM port. Each incoming request carries an address and a flag that says whether the initiator is secure. The block decides in one registered cycle whether the request may proceed (grant) or must be refused (deny). Protection is described by eight programmable regions with megabyte granularity. A separate "everything else" policy covers every address that no enabled region claims. A global bypass bit opens all memory.

Software configures the filter through a small 32-bit register port. The upper halfword of every write is a per-bit mask over the lower halfword, so single fields can be changed without a read-modify-write. Reads return the stored halfword with the upper halfword zero. At reset the filter is fully open: the bypass is set, all regions are disabled and the catch-all policy is open. Software programs the regions first and then clears the bypass. Bus protocol adaptation and error responses are handled outside the block.

Top module: `mem_region_filter`

## Requirements
- R1: After reset every configuration word reads 0x0000, except index 21, which reads 0x8000 (bypass set, catch-all open). `rsp_grant` and `rsp_deny` are low.
- R2: A write updates bit k (0..15) of the addressed word only when `cfg_wdata[16+k]` is 1. Every other bit keeps its value, and a write with an all-zero mask changes nothing.
- R3: Region n (0..7) uses two words. The word at index 6+2n holds the first megabyte in bits 11:0, a secure-select bit in bit 14 and an enable bit in bit 15. The word at index 7+2n holds the last megabyte in bits 11:0. Index 21 also holds the bypass bit (bit 15) and the catch-all secure bit (bit 14). Writes to indices outside 6..21 are ignored, and reads of those indices return zero.
- R4: A region matches an address when start <= addr[31:20] <= end, both bounds inclusive. A region whose end is below its start matches nothing.
- R5: While the bypass bit is 1, every valid request is granted.
- R6: Every valid request with `req_secure` high is granted.
- R7: A non-secure request with the bypass clear is handled as follows. It is denied if any enabled region with select 1 matches. Otherwise it is granted if any enabled region with select 0 matches. Otherwise the catch-all bit decides: 1 denies, 0 grants. Disabled regions take no part.
- R8: A request sampled with `req_valid` high at a clock edge produces exactly one of `rsp_grant` or `rsp_deny` for the one following cycle. No request produces neither output.
- R9: A read strobe at a clock edge loads `cfg_rdata` with {16'h0, word} in the following cycle. `cfg_rdata` holds its value while no read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_rd_en | input | 1 | Configuration read strobe |
| cfg_idx | input | 5 | Configuration word index |
| cfg_wdata | input | 32 | Write mask (31:16) and write data (15:0) |
| cfg_rdata | output | 32 | Read data, upper halfword zero |
| req_valid | input | 1 | Request valid |
| req_addr | input | 32 | Request byte address |
| req_secure | input | 1 | Request comes from a secure initiator |
| rsp_grant | output | 1 | Access allowed, one-cycle pulse |
| rsp_deny | output | 1 | Access refused, one-cycle pulse |

## Verification
The bench builds the block with its default parameters: eight regions, a 32-bit address and a 1 MB granule. These defaults bring the full register index range 6..21 and the shared bypass/catch-all word within reach. Random configuration writes limit the bound fields to the lowest 64 megabytes, and random request addresses stay inside the same span. This makes overlaps, inverted bounds, open windows inside a secure catch-all and bypass toggling occur often. Directed cases fix the inclusive single-megabyte region, the 32 MB example and partial-mask updates.

// File: rtl/mrf_pkg.sv
package mrf_pkg;
    localparam int WORD_W   = 16;
    localparam int SEL_BIT  = 14;
    localparam int EN_BIT   = 15;
    localparam int XSEC_BIT = 14;
    localparam int BYP_BIT  = 15;

    function automatic logic [WORD_W-1:0] masked_merge(
        input logic [WORD_W-1:0] old_w,
        input logic [WORD_W-1:0] mask,
        input logic [WORD_W-1:0] data
    );
        return (old_w & ~mask) | (data & mask);
    endfunction
endpackage

// File: rtl/mrf_cfg_regs.sv
module mrf_cfg_regs
    import mrf_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter int FIRST_IDX   = 6,
    parameter int IDX_W       = 5,
    localparam int NUM_WORDS  = 2 * NUM_REGIONS
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic                        rd_en,
    input  logic [IDX_W-1:0]            idx,
    input  logic [31:0]                 wdata,
    output logic [WORD_W-1:0]           rdata,
    output logic [NUM_WORDS*WORD_W-1:0] words
);
    typedef struct packed {
        logic [NUM_WORDS-1:0][WORD_W-1:0] words;
        logic [WORD_W-1:0]                rdata;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (wr_en && (idx == IDX_W'(FIRST_IDX + w))) begin
                st_d.words[w] = masked_merge(st_q.words[w], wdata[31:16], wdata[15:0]);
            end
        end
        if (rd_en) begin
            st_d.rdata = '0;
            for (int w = 0; w < NUM_WORDS; w++) begin
                if (idx == IDX_W'(FIRST_IDX + w)) begin
                    st_d.rdata = st_q.words[w];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
            st_q.words[NUM_WORDS-1][BYP_BIT] <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.rdata;
    assign words = st_q.words;
endmodule

// File: rtl/mrf_region_match.sv
module mrf_region_match #(
    parameter int PAGE_W = 12
) (
    input  logic [PAGE_W-1:0] first_pg,
    input  logic [PAGE_W-1:0] last_pg,
    input  logic [PAGE_W-1:0] page,
    output logic              hit
);
    assign hit = (page >= first_pg) && (page <= last_pg);
endmodule

// File: rtl/mrf_policy.sv
module mrf_policy
    import mrf_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter int PAGE_W      = 12,
    localparam int NUM_WORDS  = 2 * NUM_REGIONS
) (
    input  logic [NUM_WORDS*WORD_W-1:0] words,
    input  logic [PAGE_W-1:0]           page,
    input  logic                        secure,
    output logic                        allow
);
    logic [NUM_REGIONS-1:0] hit, en, sel;
    logic                   secure_hit, open_hit, bypass, xsec;
    logic                   unused_words;

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_rgn
        logic [WORD_W-1:0] w_first, w_last;
        assign w_first = words[(2*r)*WORD_W +: WORD_W];
        assign w_last  = words[(2*r+1)*WORD_W +: WORD_W];
        assign en[r]   = w_first[EN_BIT];
        assign sel[r]  = w_first[SEL_BIT];

        mrf_region_match #(.PAGE_W(PAGE_W)) u_match (
            .first_pg (w_first[PAGE_W-1:0]),
            .last_pg  (w_last[PAGE_W-1:0]),
            .page     (page),
            .hit      (hit[r])
        );
    end

    assign bypass       = words[(NUM_WORDS-1)*WORD_W + BYP_BIT];
    assign xsec         = words[(NUM_WORDS-1)*WORD_W + XSEC_BIT];
    assign secure_hit   = |(hit & en & sel);
    assign open_hit     = |(hit & en & ~sel);
    assign allow        = secure || bypass || (!secure_hit && (open_hit || !xsec));
    assign unused_words = ^words;
endmodule

// File: rtl/mem_region_filter.sv
module mem_region_filter
    import mrf_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter int ADDR_W      = 32,
    parameter int GRAN_SHIFT  = 20,
    parameter int FIRST_IDX   = 6,
    parameter int IDX_W       = 5,
    localparam int PAGE_W     = ADDR_W - GRAN_SHIFT,
    localparam int NUM_WORDS  = 2 * NUM_REGIONS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic              cfg_rd_en,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_secure,
    output logic              rsp_grant,
    output logic              rsp_deny
);
    typedef struct packed {
        logic grant;
        logic deny;
    } resp_t;

    resp_t                       resp_d, resp_q;
    logic [NUM_WORDS*WORD_W-1:0] cfg_words;
    logic [WORD_W-1:0]           rdata_w;
    logic                        allow;
    logic                        unused_low;

    mrf_cfg_regs #(
        .NUM_REGIONS (NUM_REGIONS),
        .FIRST_IDX   (FIRST_IDX),
        .IDX_W       (IDX_W)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cfg_wr_en),
        .rd_en (cfg_rd_en),
        .idx   (cfg_idx),
        .wdata (cfg_wdata),
        .rdata (rdata_w),
        .words (cfg_words)
    );

    mrf_policy #(
        .NUM_REGIONS (NUM_REGIONS),
        .PAGE_W      (PAGE_W)
    ) u_policy (
        .words  (cfg_words),
        .page   (req_addr[ADDR_W-1:GRAN_SHIFT]),
        .secure (req_secure),
        .allow  (allow)
    );

    always_comb begin
        resp_d       = '0;
        resp_d.grant = req_valid && allow;
        resp_d.deny  = req_valid && !allow;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_q <= '0;
        end else begin
            resp_q <= resp_d;
        end
    end

    assign rsp_grant  = resp_q.grant;
    assign rsp_deny   = resp_q.deny;
    assign cfg_rdata  = {16'h0, rdata_w};
    assign unused_low = ^req_addr[GRAN_SHIFT-1:0];
endmodule

// File: rtl/mrf_checker.sv
module mrf_checker #(
    parameter int WORDS_W = 256
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_secure,
    input logic               cfg_wr_en,
    input logic [15:0]        cfg_mask,
    input logic [WORDS_W-1:0] cfg_words,
    input logic               rsp_grant,
    input logic               rsp_deny
);
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_grant && rsp_deny));

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_grant && !rsp_deny));

    a_r8_answered: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_grant || rsp_deny));

    a_r6_secure_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_secure) |=> rsp_grant);

    a_r5_bypass_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cfg_words[WORDS_W-1]) |=> rsp_grant);

    a_r2_zero_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_wr_en || cfg_mask == 16'h0) |=> $stable(cfg_words));
endmodule

bind mem_region_filter mrf_checker #(.WORDS_W(2 * NUM_REGIONS * 16)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_secure (req_secure),
    .cfg_wr_en  (cfg_wr_en),
    .cfg_mask   (cfg_wdata[31:16]),
    .cfg_words  (cfg_words),
    .rsp_grant  (rsp_grant),
    .rsp_deny   (rsp_deny)
);

// File: tb/tb_mem_region_filter.sv
module tb_mem_region_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0, cfg_rd_en = 1'b0;
    logic [4:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0, req_secure = 1'b0;
    logic [31:0] req_addr = '0;
    logic        rsp_grant, rsp_deny;

    int tests = 0, fails = 0;
    bit done = 0;
    logic [15:0] mdl [0:15];

    always #5 clk = ~clk;

    mem_region_filter dut (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit exp_allow(logic [31:0] a, bit s);
        bit sh = 0, oh = 0;
        logic [11:0] pg = a[31:20];
        for (int r = 0; r < 8; r++) begin
            if (mdl[2*r][15] && pg >= mdl[2*r][11:0] && pg <= mdl[2*r+1][11:0]) begin
                if (mdl[2*r][14]) sh = 1; else oh = 1;
            end
        end
        return s || mdl[15][15] || (!sh && (oh || !mdl[15][14]));
    endfunction

    function automatic logic [15:0] exp_word(int i);
        return (i >= 6 && i <= 21) ? mdl[i-6] : 16'h0;
    endfunction

    task automatic wr(int i, logic [15:0] m, logic [15:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_idx = 5'(i); cfg_wdata = {m, d};
        @(negedge clk);
        cfg_wr_en = 1'b0;
        if (i >= 6 && i <= 21) mdl[i-6] = (mdl[i-6] & ~m) | (d & m);
    endtask

    task automatic rd(int i, string req);
        @(negedge clk);
        cfg_rd_en = 1'b1; cfg_idx = 5'(i);
        @(negedge clk);
        cfg_rd_en = 1'b0;
        chk(req, cfg_rdata, {16'h0, exp_word(i)});
    endtask

    task automatic rq(logic [31:0] a, bit s, string req);
        bit e;
        e = exp_allow(a, s);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_secure = s;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req, {30'h0, rsp_grant, rsp_deny}, {30'h0, e, !e});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16; i++) mdl[i] = 16'h0;
        mdl[15] = 16'h8000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 outputs idle", {30'h0, rsp_grant, rsp_deny}, 32'h0);
        rd(21, "R1 last word reset");
        rd(6, "R1 region word reset");
        // R5 bypass open at reset
        rq(32'h1234_5678, 0, "R5 bypass after reset");
        wr(6, 16'hFFFF, 16'hC000);
        wr(7, 16'hFFFF, 16'd31);
        rq(32'h0100_0000, 0, "R5 bypass overrides region");
        // clear bypass (R2 single-bit mask)
        wr(21, 16'h8000, 16'h0000);
        rd(21, "R2 mask clears only bypass");
        // R4 32 MB region, inclusive end
        rq(32'h01F0_0000, 0, "R4 last megabyte covered");
        rq(32'h0200_0000, 0, "R4 past end open");
        rq(32'h0000_0000, 1, "R6 secure initiator granted");
        // R2 partial mask
        wr(7, 16'h00FF, 16'hFF05);
        rd(7, "R2 partial mask");
        rq(32'h0060_0000, 0, "R2 new end effective");
        rq(32'h0050_0000, 0, "R2 new end inclusive");
        // R4 single megabyte region
        wr(7, 16'hFFFF, 16'h0000);
        rq(32'h000F_FFFF, 0, "R4 start=end=0 covers first MB");
        rq(32'h0010_0000, 0, "R4 start=end=0 stops at 1MB");
        // R4 inverted bounds
        wr(10, 16'hFFFF, 16'hC000 | 16'd40);
        wr(11, 16'hFFFF, 16'd30);
        rq(32'h0230_0000, 0, "R4 inverted region no match");
        rq(32'h0280_0000, 0, "R4 inverted region at start");
        // R7 catch-all and open windows
        wr(21, 16'h4000, 16'h4000);
        rq(32'h0640_0000, 0, "R7 catch-all secure denies");
        wr(12, 16'hFFFF, 16'h8000 | 16'd100);
        wr(13, 16'hFFFF, 16'd100);
        rq(32'h0640_0000, 0, "R7 open window grants");
        wr(14, 16'hFFFF, 16'hC000 | 16'd100);
        wr(15, 16'hFFFF, 16'd100);
        rq(32'h0640_0000, 0, "R7 secure region wins overlap");
        wr(14, 16'h8000, 16'h0000);
        rq(32'h0640_0000, 0, "R7 disabled region ignored");
        // R3 out-of-range indices
        wr(3, 16'hFFFF, 16'hFFFF);
        wr(22, 16'hFFFF, 16'hFFFF);
        rd(3, "R3 index below range reads zero");
        rd(22, "R3 index above range reads zero");
        rq(32'h0640_0000, 0, "R3 stray writes no effect");
        // R8 idle cycle
        @(negedge clk);
        @(negedge clk);
        chk("R8 no request no response", {30'h0, rsp_grant, rsp_deny}, 32'h0);
        // R9 read holds
        rd(12, "R9 read word");
        @(negedge clk);
        chk("R9 read data held", cfg_rdata, {16'h0, exp_word(12)});
        // R5 bypass again
        wr(21, 16'h8000, 16'h8000);
        rq(32'h0000_0000, 0, "R5 bypass reenabled");
        wr(21, 16'h8000, 16'h0000);
        // random mix
        for (int n = 0; n < 600; n++) begin
            int k;
            k = $urandom_range(0, 9);
            if (k < 3) begin
                wr($urandom_range(4, 23), 16'($urandom), 16'($urandom) & 16'hC03F);
            end else if (k == 3) begin
                rd($urandom_range(4, 23), "R9 random read");
            end else begin
                rq({6'h0, 6'($urandom), 20'($urandom)}, ($urandom_range(0, 4) == 0), "R7 random request");
            end
        end
        finish_run();
    end
endmodule